// File: doc/BRIEF.md
# Buffered UART Transmitter

This block is the transmit half of a UART. Characters of up to nine bits come in on a one-cycle write strobe. The block holds them in a local buffer and turns them into frames on the serial line. Bit timing comes from an external one-cycle baud tick. Software starts and stops the sending of new frames with a run enable. It can also hold back new frames until the far end raises its clear-to-send input.

The buffer works in one of two modes, picked by `fifo_mode`:

- **Queue mode:** a 16-entry first-in first-out store. Writes made while it is full are dropped.
- **Single-slot mode:** one holding slot. A write made while the slot is occupied replaces its contents.

In both modes, a write that arrives while the shift register is empty goes straight into the shift register. When a frame reaches its stop bit, the next character is pulled from the buffer at once, so consecutive frames leave no idle gap.

A loopback control moves the serial stream off the pin and onto a tap for an on-chip receiver. The flush strobe empties the buffer, and software issues it after changing buffer mode.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset `tx_line` and `loop_tap` are 1, `tx_empty` and `tx_half_empty` are 1, and `tx_full` is 0.
- R2: A frame is a low start bit, then data bits 0..7 with the least significant bit first, then bit 8 only when `nine_bit` is 1, then one high stop bit. The line changes only on the clock edge that samples `baud_tick` high, so each bit lasts one tick interval. The line is high between frames.
- R3: A frame's start bit begins only on an edge where `baud_tick` and `run_en` are 1 and either `cts_en` is 0 or `cts` is 1. A frame already in progress finishes regardless of these inputs.
- R4: A write made while the shift register is empty and the buffer is empty loads the shift register on that edge and leaves the buffer empty. The start bit follows on the next qualifying tick.
- R5: On the tick that enters the stop bit, the shift register takes the oldest buffered character, or the write present on that edge if the buffer is empty. That character's start bit may then begin on the very next tick, with no extra idle bit.
- R6: `tx_empty` is 1 only while no frame is in its start or data bits and no character waits in the shift register. It rises in the first cycle of the stop bit of the last frame.
- R7: With `fifo_mode`=1 the buffer holds up to 16 characters in order, and `tx_full` is 1 exactly at 16. A write while full is discarded and leaves every stored entry unchanged.
- R8: With `fifo_mode`=1, `tx_half_empty` is 1 exactly when the buffer holds 8 or fewer characters.
- R9: With `fifo_mode`=0 the buffer holds one character. `tx_full` is 1 when it is occupied, and `tx_half_empty` is 1 when it is empty. A write while it is occupied overwrites it.
- R10: `tx_flush` empties the buffer on that edge, and a write on the same edge is dropped. A character already in the shift register is still sent.
- R11: With `loop_en`=1 the serial stream appears on `loop_tap` and `tx_line` is held at 1. With `loop_en`=0, `loop_tap` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle bit-period pulse |
| run_en | input | 1 | Allows new frames to start |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear-to-send from the far end |
| nine_bit | input | 1 | Send data bit 8 |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single slot |
| loop_en | input | 1 | Route the serial stream to `loop_tap` |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 9 | Character to send |
| tx_flush | input | 1 | Empty the buffer |
| tx_line | output | 1 | Serial output, idle high |
| loop_tap | output | 1 | Internal serial path to a receiver |
| tx_empty | output | 1 | No frame pending or in its data bits |
| tx_full | output | 1 | Buffer full |
| tx_half_empty | output | 1 | Buffer at or below its low mark |

## Verification
The bench targets the following corner cases:

- **Write on the stop-entry tick.** A design that ignores a write arriving on the tick that enters the stop bit would add an idle bit between frames, or would lose that character.
- **Queue at capacity.** Writing the queue past 16 entries exposes a design that overwrites the newest stored entry, or wraps its pointers, instead of dropping the extra write. Either fault would send an unexpected character.
- **Single-slot overwrite.** In single-slot mode a second write must replace the held character. A design that queues it instead would send one character too many.
- **Gating and flush.** Clearing run, or holding clear-to-send low, must keep the line idle. A flush must leave the shift register alone, so the character in it still goes out.

All of this is compared cycle by cycle against a queue-based reference. The compared values are the line, the tap and all three flags.

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered #(
  parameter int DEPTH = 16,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          run_en,
  input  logic          cts_en,
  input  logic          cts,
  input  logic          nine_bit,
  input  logic          fifo_mode,
  input  logic          loop_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_flush,
  output logic          tx_line,
  output logic          loop_tap,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          tx_half_empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(DW + 2);
  localparam logic [1:0] S_IDLE = 2'd0, S_SEND = 2'd1, S_STOP = 2'd2;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] count_q;
  logic [1:0]    state_q;
  logic [BW-1:0] bit_q, last_bit;
  logic [DW-1:0] sh_q, load_data;
  logic          sh_full_q;
  logic          in_send, gate, stop_entry, frame_go, slot_free;
  logic          buf_any, pop, bypass, wr_ok, push, ovw, out_bit;

  assign in_send    = state_q == S_SEND;
  assign last_bit   = nine_bit ? BW'(DW) : BW'(DW - 1);
  assign gate       = baud_tick & run_en & (~cts_en | cts);
  assign stop_entry = in_send & baud_tick & (bit_q == last_bit);
  assign frame_go   = ~in_send & sh_full_q & gate;
  assign slot_free  = (~in_send & ~sh_full_q) | stop_entry;
  assign buf_any    = count_q != '0;
  assign pop        = slot_free & ~tx_flush & buf_any;
  assign bypass     = slot_free & ~tx_flush & ~buf_any & wr_en;
  assign load_data  = pop ? mem[rd_q] : wr_data;
  assign wr_ok      = wr_en & ~tx_flush & ~bypass;
  assign push       = wr_ok & (fifo_mode ? (count_q != CW'(DEPTH)) : (~buf_any | pop));
  assign ovw        = wr_ok & ~fifo_mode & buf_any & ~pop;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wr_data;
    else if (ovw) mem[wr_q - PW'(1)] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
      count_q <= '0;
    end else if (tx_flush) begin
      rd_q <= '0;
      wr_q <= '0;
      count_q <= '0;
    end else begin
      if (pop) rd_q <= rd_q + PW'(1);
      if (push) wr_q <= wr_q + PW'(1);
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      sh_full_q <= 1'b0;
    end else begin
      if (frame_go) begin
        state_q   <= S_SEND;
        bit_q     <= '0;
        sh_full_q <= 1'b0;
      end else if (in_send && baud_tick) begin
        if (bit_q == last_bit) state_q <= S_STOP;
        else bit_q <= bit_q + BW'(1);
      end else if (state_q == S_STOP && baud_tick) begin
        state_q <= S_IDLE;
      end
      if (pop || bypass) begin
        sh_q      <= load_data;
        sh_full_q <= 1'b1;
      end
    end
  end

  assign out_bit       = in_send ? ((bit_q == '0) ? 1'b0 : sh_q[bit_q - BW'(1)]) : 1'b1;
  assign tx_line       = loop_en ? 1'b1 : out_bit;
  assign loop_tap      = loop_en ? out_bit : 1'b1;
  assign tx_empty      = ~in_send & ~sh_full_q;
  assign tx_full       = fifo_mode ? (count_q == CW'(DEPTH)) : buf_any;
  assign tx_half_empty = fifo_mode ? (count_q <= CW'(DEPTH / 2)) : ~buf_any;
endmodule

module uart_tx_buffered_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          run_en,
  input logic          cts_en,
  input logic          cts,
  input logic          fifo_mode,
  input logic          loop_en,
  input logic          wr_en,
  input logic          tx_flush,
  input logic          tx_line,
  input logic          loop_tap,
  input logic          tx_full,
  input logic          tx_half_empty,
  input logic [1:0]    st,
  input logic [CW-1:0] fill
);
  logic ser;
  assign ser = tx_line & loop_tap;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  assert_gated_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == 2'd1) |-> $past(baud_tick && run_en && (!cts_en || cts)));

  assert_bit_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ser) && $stable(loop_en)) |-> $past(baud_tick));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_half_empty && !tx_full));

  assert_slot_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && tx_full && wr_en && !tx_flush) ##1 !fifo_mode |-> tx_full);

  assert_full_not_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && tx_full) |-> !tx_half_empty);
endmodule

bind uart_tx_buffered uart_tx_buffered_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .run_en(run_en),
  .cts_en(cts_en), .cts(cts), .fifo_mode(fifo_mode), .loop_en(loop_en),
  .wr_en(wr_en), .tx_flush(tx_flush), .tx_line(tx_line), .loop_tap(loop_tap),
  .tx_full(tx_full), .tx_half_empty(tx_half_empty), .st(state_q), .fill(count_q)
);

// File: tb/test_uart_tx_buffered.sv
`timescale 1ns/1ps
module test_uart_tx_buffered;
  logic clk = 0, rst_n = 0;
  logic baud_tick = 0, run_en = 0, cts_en = 0, cts = 0, nine_bit = 0;
  logic fifo_mode = 0, loop_en = 0, wr_en = 0, tx_flush = 0;
  logic [8:0] wr_data = '0;
  logic tx_line, loop_tap, tx_empty, tx_full, tx_half_empty;

  int checks = 0, errors = 0, div = 4, tcnt = 0;

  always #10 clk = ~clk;

  uart_tx_buffered i_uart_tx_buffered (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .run_en(run_en),
    .cts_en(cts_en), .cts(cts), .nine_bit(nine_bit), .fifo_mode(fifo_mode),
    .loop_en(loop_en), .wr_en(wr_en), .wr_data(wr_data), .tx_flush(tx_flush),
    .tx_line(tx_line), .loop_tap(loop_tap), .tx_empty(tx_empty),
    .tx_full(tx_full), .tx_half_empty(tx_half_empty)
  );

  // reference model: 0 idle, 1 sending start/data, 2 stop bit
  int mq[$];
  int mst, mbc, mact, mpend;
  bit mpv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mst = 0; mbc = 0; mact = 0; mpend = 0; mpv = 0;
    end else begin
      int lastb, old_size, nd;
      bit gate, stop_e, go, free, popq, byp;
      lastb = nine_bit ? 9 : 8;
      gate = baud_tick && run_en && (!cts_en || cts);
      stop_e = (mst == 1) && baud_tick && (mbc == lastb);
      go = (mst != 1) && mpv && gate;
      free = ((mst != 1) && !mpv) || stop_e;
      old_size = mq.size();
      popq = free && !tx_flush && old_size > 0;
      byp = free && !tx_flush && old_size == 0 && wr_en;
      nd = popq ? mq[0] : int'(wr_data);
      if (tx_flush) mq.delete();
      else begin
        if (popq) void'(mq.pop_front());
        if (wr_en && !byp) begin
          if (fifo_mode) begin
            if (old_size < 16) mq.push_back(int'(wr_data));
          end else if (old_size == 0 || popq) mq.push_back(int'(wr_data));
          else mq[mq.size()-1] = int'(wr_data);
        end
      end
      if (go) begin mst = 1; mbc = 0; mact = mpend; mpv = 0; end
      else if (mst == 1 && baud_tick) begin
        if (mbc == lastb) mst = 2; else mbc++;
      end else if (mst == 2 && baud_tick) mst = 0;
      if (popq || byp) begin mpend = nd; mpv = 1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ser();
    if (mst != 1) return 1;
    if (mbc == 0) return 0;
    return (mact >> (mbc - 1)) & 1;
  endfunction

  task automatic compare();
    int s, ef, eh, ee;
    s = exp_ser();
    ef = fifo_mode ? int'(mq.size() == 16) : int'(mq.size() != 0);
    eh = fifo_mode ? int'(mq.size() <= 8) : int'(mq.size() == 0);
    ee = int'(mst != 1 && !mpv);
    chk(tx_line == (loop_en ? 1 : s), "tx_line R2 R3 R5", tx_line, loop_en ? 1 : s);
    chk(loop_tap == (loop_en ? s : 1), "loop_tap R11", loop_tap, loop_en ? s : 1);
    chk(tx_empty == ee, "tx_empty R4 R6", tx_empty, ee);
    chk(tx_full == ef, fifo_mode ? "tx_full R7" : "tx_full R9", tx_full, ef);
    chk(tx_half_empty == eh, fifo_mode ? "tx_half_empty R8" : "tx_half_empty R9", tx_half_empty, eh);
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare();
    wr_en = 0; tx_flush = 0;
    baud_tick = (tcnt == div - 1);
    tcnt = (tcnt + 1) % div;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic put(input int d);
    step(); wr_en = 1; wr_data = 9'(d);
  endtask

  task automatic flush();
    step(); tx_flush = 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 4000; i++) begin
      step();
      if (tx_empty && mst == 0) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0h expected %0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_line == 1 && loop_tap == 1, "reset line R1", tx_line, 1);
    chk(tx_empty == 1 && tx_half_empty == 1 && tx_full == 0, "reset flags R1",
        {tx_empty, tx_half_empty, tx_full}, 3'b110);

    // single-slot bypass into an idle shift register
    run_en = 1;
    put(9'h0A5); step();
    chk(tx_empty == 0 && tx_half_empty == 1, "bypass R4", {tx_empty, tx_half_empty}, 2'b01);
    for (int i = 0; i < 200; i++) begin
      step();
      if (tx_empty) break;
    end
    chk(tx_empty == 1 && tx_line == 1 && mst == 2, "empty at stop R6", tx_empty, 1);
    drain();

    // gating by run and clear-to-send
    run_en = 0; put(9'h03C); idle(40);
    chk(tx_line == 1, "run low holds line R3", tx_line, 1);
    cts_en = 1; cts = 0; run_en = 1; idle(40);
    chk(tx_line == 1, "cts low holds line R3", tx_line, 1);
    cts = 1; drain(); cts_en = 0;

    // queue mode, back-to-back frames with slow and fast ticks
    flush(); fifo_mode = 1;
    for (int k = 0; k < 5; k++) put(9'h011 * k + 9'h40);
    drain();
    div = 1;
    for (int k = 0; k < 4; k++) put(9'h0F0 ^ k);
    drain();
    div = 3;

    // queue overflow: one in shifter, 16 stored, extras dropped
    run_en = 0; flush();
    for (int k = 0; k < 20; k++) put(9'h080 + k);
    step();
    chk(tx_full == 1, "queue full R7", tx_full, 1);
    chk(tx_half_empty == 0, "queue above half R8", tx_half_empty, 0);
    run_en = 1; drain();
    chk(tx_half_empty == 1 && tx_full == 0, "queue drained R8", tx_half_empty, 1);

    // single-slot overwrite
    flush(); fifo_mode = 0; run_en = 0;
    put(9'h011); put(9'h022); put(9'h033); step();
    chk(tx_full == 1 && tx_half_empty == 0, "slot held R9", {tx_full, tx_half_empty}, 2'b10);
    run_en = 1; drain();

    // flush keeps the shifter
    run_en = 0; put(9'h0C3); put(9'h05A); flush(); step();
    chk(tx_half_empty == 1 && tx_full == 0, "flush empties R10", tx_half_empty, 1);
    chk(tx_empty == 0, "flush keeps shifter R10", tx_empty, 0);
    run_en = 1; drain();

    // nine-bit characters and a write on the stop-entry tick
    nine_bit = 1; fifo_mode = 1; flush();
    put(9'h1FF); put(9'h100); drain();
    put(9'h155);
    for (int i = 0; i < 200; i++) begin
      step();
      if (mst == 1 && mbc == 9 && baud_tick) begin wr_en = 1; wr_data = 9'h0AA; break; end
    end
    drain();
    nine_bit = 0;

    // loopback
    loop_en = 1; lows = 0;
    put(9'h000);
    for (int i = 0; i < 200; i++) begin
      step();
      chk(tx_line == 1, "loopback pin idle R11", tx_line, 1);
      if (loop_tap == 0) lows++;
      if (tx_empty && mst == 0) break;
    end
    chk(lows > 0, "loopback tap active R11", lows, 1);
    loop_en = 0;
    idle(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule